// File: doc/BRIEF.md
# Multi-Target Completion Aggregator

This block waits on one request that was sent out to several downstream targets, and it produces a single completion record once the request is settled. The launch side names the request with a correlation tag. It also gives a bitmask of the targets involved, where bit i stands for target i, and picks a failure policy. Each target then sends back one report on a shared stream. A report carries the tag, the index of the sending target, an ok bit and an error code. The value 0 of the error code means "no error".

Two policies are available. Under fail-fast (`launch_collect` = 0, the default choice), the first failing report ends the request at once. Under collect-all (`launch_collect` = 1), the block waits for every target in the mask. It then reports ok only if every target succeeded. Otherwise it returns the code of the failing target with the lowest index. Only one request is in flight at a time. A new launch is refused until the upstream side has taken the result.

Reports that break the protocol set a sticky flag and are otherwise dropped. A report breaks the protocol when it has the wrong tag, comes from a target outside the mask, repeats a target, or has an ok bit and error code that disagree. The output never violates the ok/code rule.

Top module: `cmpl_join`

## Requirements
- R1: After reset, `launch_ready` is 1, `res_valid` is 0 and `proto_err` is 0.
- R2: A launch is taken on a cycle where `launch_valid` and `launch_ready` are both 1. From the next cycle on, `launch_ready` stays 0. It returns to 1 on the cycle after the result handshake, which is `res_valid` and `res_ready` both at 1.
- R3: A legal report meets all of these conditions: its tag equals the active tag, its target index `rpt_src` is i with mask bit i set, and that target has not reported before. When the last masked target delivers a legal report, `res_valid` rises one cycle after the edge that samples it. If every report had ok = 1, the result has `res_ok` = 1, `res_err` = 0 and the launch tag.
- R4: Under fail-fast, the first legal report with ok = 0 gives a result one cycle later, without waiting for the other targets. That result has `res_ok` = 0 and carries the report's error code.
- R5: After a fail-fast result, legal reports that still arrive from unreported targets of that tag are absorbed until the next launch. They produce no result and do not set `proto_err`.
- R6: Under collect-all, no result appears before every masked target has reported. If any report failed, the result has `res_ok` = 0 and the error code of the failing target with the lowest index.
- R7: Whenever `res_valid` is 1, `res_ok` = 1 implies `res_err` = 0 and `res_ok` = 0 implies `res_err` ≠ 0. While `res_valid` is 1 and `res_ready` is 0, the tag, ok and code outputs hold steady.
- R8: `proto_err` is set by any of these reports: a tag mismatch, a target outside the mask (including indices of N_TGT or above), a repeated target, or any report while no request is open. The flag then stays 1 until reset. Such a report does not count toward completion.
- R9: A report is handled as in R8 when its ok bit and code disagree, that is ok = 1 with a nonzero code, or ok = 0 with code 0.
- R10: A launch with an all-zero mask produces an ok result with code 0 and no reports needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_valid | input | 1 | Launch request present |
| launch_ready | output | 1 | Block can accept a launch |
| launch_tag | input | TAG_W | Correlation tag of the request |
| launch_mask | input | N_TGT | Targets involved, bit i = target i |
| launch_collect | input | 1 | 0 = fail-fast, 1 = collect-all |
| rpt_valid | input | 1 | Completion report present |
| rpt_tag | input | TAG_W | Tag of the report |
| rpt_src | input | SRC_W | Index of the reporting target |
| rpt_ok | input | 1 | Target succeeded |
| rpt_err | input | ERR_W | Target error code, 0 = none |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Upstream takes the result |
| res_tag | output | TAG_W | Tag of the result |
| res_ok | output | 1 | Aggregate success |
| res_err | output | ERR_W | Aggregate error code, 0 when ok |
| proto_err | output | 1 | Sticky protocol violation flag |

## Verification
The bench builds the block with N_TGT = 5, TAG_W = 4 and ERR_W = 3. Five targets need a 3-bit source index, so the unused indices 5 to 7 can be driven. This exercises the out-of-range branch of the protocol check. With five targets, the lowest-index error choice can also be tested with failures in the middle and at the top of the mask, in any arrival order. The narrow error code keeps codes of 1 to 7 distinct, so a result code shows which failing report it came from.

// File: rtl/cmpl_join_pkg.sv
package cmpl_join_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_HOLD = 2'd2
  } cj_state_e;
endpackage

// File: rtl/cj_report_check.sv
module cj_report_check #(
  parameter int N_TGT = 4,
  parameter int TAG_W = 8,
  parameter int ERR_W = 4,
  parameter int SRC_W = 2
) (
  input  logic             rpt_valid,
  input  logic [TAG_W-1:0] rpt_tag,
  input  logic [SRC_W-1:0] rpt_src,
  input  logic             rpt_ok,
  input  logic [ERR_W-1:0] rpt_err,
  input  logic [TAG_W-1:0] cur_tag,
  input  logic [N_TGT-1:0] pending,
  input  logic             open,
  output logic [N_TGT-1:0] hit_vec,
  output logic             bad,
  output logic             fail
);
  logic [N_TGT-1:0] src_oh;
  logic             code_sane;
  logic             legal;

  for (genvar g = 0; g < N_TGT; g++) begin : g_dec
    assign src_oh[g] = (rpt_src == SRC_W'(g));
  end

  assign code_sane = rpt_ok ? (rpt_err == '0) : (rpt_err != '0);
  assign legal = rpt_valid && open && (rpt_tag == cur_tag)
              && ((src_oh & pending) != '0) && code_sane;
  assign hit_vec = legal ? src_oh : '0;
  assign bad     = rpt_valid && !legal;
  assign fail    = legal && !rpt_ok;
endmodule

// File: rtl/cj_err_pick.sv
module cj_err_pick #(
  parameter int N_TGT = 4,
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             clear,
  input  logic [N_TGT-1:0] hit_vec,
  input  logic             fail,
  input  logic [ERR_W-1:0] rpt_err,
  output logic             any_fail,
  output logic [ERR_W-1:0] pick_err
);
  logic [N_TGT-1:0] fail_q;
  logic [N_TGT-1:0] fail_n;
  logic [ERR_W-1:0] err_q [N_TGT];
  logic [ERR_W-1:0] err_n [N_TGT];

  for (genvar g = 0; g < N_TGT; g++) begin : g_slot
    assign fail_n[g] = fail_q[g] | (hit_vec[g] & fail);
    assign err_n[g]  = hit_vec[g] ? rpt_err : err_q[g];

    always_ff @(posedge clk) begin
      if (clear) fail_q[g] <= 1'b0;
      else       fail_q[g] <= fail_n[g];
      if (hit_vec[g] && fail) err_q[g] <= rpt_err;
    end
  end

  assign any_fail = (fail_n != '0);

  always_comb begin
    pick_err = '0;
    for (int i = N_TGT - 1; i >= 0; i--) begin
      if (fail_n[i]) pick_err = err_n[i];
    end
  end
endmodule

// File: rtl/cmpl_join.sv
module cmpl_join
  import cmpl_join_pkg::*;
#(
  parameter int N_TGT = 4,
  parameter int TAG_W = 8,
  parameter int ERR_W = 4,
  localparam int SRC_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch_valid,
  output logic             launch_ready,
  input  logic [TAG_W-1:0] launch_tag,
  input  logic [N_TGT-1:0] launch_mask,
  input  logic             launch_collect,
  input  logic             rpt_valid,
  input  logic [TAG_W-1:0] rpt_tag,
  input  logic [SRC_W-1:0] rpt_src,
  input  logic             rpt_ok,
  input  logic [ERR_W-1:0] rpt_err,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [TAG_W-1:0] res_tag,
  output logic             res_ok,
  output logic [ERR_W-1:0] res_err,
  output logic             proto_err
);
  cj_state_e        state_q;
  logic [TAG_W-1:0] tag_q;
  logic [N_TGT-1:0] pend_q;
  logic             collect_q;
  logic             drain_q;

  logic             busy;
  logic             open_w;
  logic             launch_go;
  logic [N_TGT-1:0] hit_vec;
  logic             rpt_bad;
  logic             rpt_fail;
  logic [N_TGT-1:0] pend_after;
  logic             ff_trip;
  logic             all_in;
  logic             any_fail;
  logic [ERR_W-1:0] pick_err;
  logic             nxt_ok;
  logic [ERR_W-1:0] nxt_err;

  assign busy         = (state_q == ST_BUSY);
  assign open_w       = busy || drain_q;
  assign launch_ready = (state_q == ST_IDLE);
  assign launch_go    = launch_valid && launch_ready;

  cj_report_check #(
    .N_TGT(N_TGT), .TAG_W(TAG_W), .ERR_W(ERR_W), .SRC_W(SRC_W)
  ) u_check (
    .rpt_valid(rpt_valid),
    .rpt_tag  (rpt_tag),
    .rpt_src  (rpt_src),
    .rpt_ok   (rpt_ok),
    .rpt_err  (rpt_err),
    .cur_tag  (tag_q),
    .pending  (pend_q),
    .open     (open_w),
    .hit_vec  (hit_vec),
    .bad      (rpt_bad),
    .fail     (rpt_fail)
  );

  cj_err_pick #(
    .N_TGT(N_TGT), .ERR_W(ERR_W)
  ) u_pick (
    .clk     (clk),
    .clear   (rst || launch_go),
    .hit_vec (hit_vec),
    .fail    (rpt_fail && busy),
    .rpt_err (rpt_err),
    .any_fail(any_fail),
    .pick_err(pick_err)
  );

  assign pend_after = pend_q & ~hit_vec;
  assign ff_trip    = busy && rpt_fail && !collect_q;
  assign all_in     = busy && (pend_after == '0);
  assign nxt_ok     = ff_trip ? 1'b0 : !any_fail;
  assign nxt_err    = ff_trip ? rpt_err : (any_fail ? pick_err : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      tag_q     <= '0;
      pend_q    <= '0;
      collect_q <= 1'b0;
      drain_q   <= 1'b0;
      res_valid <= 1'b0;
      res_tag   <= '0;
      res_ok    <= 1'b0;
      res_err   <= '0;
      proto_err <= 1'b0;
    end else begin
      proto_err <= proto_err | rpt_bad;
      pend_q    <= pend_after;
      case (state_q)
        ST_IDLE: begin
          if (launch_valid) begin
            tag_q     <= launch_tag;
            pend_q    <= launch_mask;
            collect_q <= launch_collect;
            drain_q   <= 1'b0;
            state_q   <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (ff_trip || all_in) begin
            res_valid <= 1'b1;
            res_tag   <= tag_q;
            res_ok    <= nxt_ok;
            res_err   <= nxt_err;
            drain_q   <= ff_trip;
            state_q   <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (res_ready) begin
            res_valid <= 1'b0;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmpl_join_chk.sv
module cmpl_join_chk #(
  parameter int N_TGT = 4,
  parameter int TAG_W = 8,
  parameter int ERR_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             launch_valid,
  input logic             launch_ready,
  input logic             res_valid,
  input logic             res_ready,
  input logic [TAG_W-1:0] res_tag,
  input logic             res_ok,
  input logic [ERR_W-1:0] res_err,
  input logic             proto_err
);
  AST_OK_NULL_CODE: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ok) |-> (res_err == '0)); // R7

  AST_FAIL_HAS_CODE: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ok) |-> (res_err != '0)); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_tag) && $stable(res_ok) && $stable(res_err))); // R7

  AST_PROTO_STICKY: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err); // R8

  AST_LAUNCH_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (launch_valid && launch_ready) |=> !launch_ready); // R2

  AST_NO_LAUNCH_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !launch_ready); // R2

  AST_REOPEN_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ready) |=> launch_ready); // R2
endmodule

bind cmpl_join cmpl_join_chk #(
  .N_TGT(N_TGT), .TAG_W(TAG_W), .ERR_W(ERR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .launch_valid(launch_valid),
  .launch_ready(launch_ready),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_tag     (res_tag),
  .res_ok      (res_ok),
  .res_err     (res_err),
  .proto_err   (proto_err)
);

// File: tb/cmpl_join_bench.sv
`timescale 1ns/1ps
module cmpl_join_bench;
  localparam int N  = 5;
  localparam int TW = 4;
  localparam int EW = 3;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          launch_valid = 1'b0;
  logic          launch_ready;
  logic [TW-1:0] launch_tag = '0;
  logic [N-1:0]  launch_mask = '0;
  logic          launch_collect = 1'b0;
  logic          rpt_valid = 1'b0;
  logic [TW-1:0] rpt_tag = '0;
  logic [SW-1:0] rpt_src = '0;
  logic          rpt_ok = 1'b0;
  logic [EW-1:0] rpt_err = '0;
  logic          res_valid;
  logic          res_ready = 1'b1;
  logic [TW-1:0] res_tag;
  logic          res_ok;
  logic [EW-1:0] res_err;
  logic          proto_err;

  always #2 clk = ~clk;

  cmpl_join #(.N_TGT(N), .TAG_W(TW), .ERR_W(EW)) u_cmpl_join (
    .clk(clk), .rst(rst),
    .launch_valid(launch_valid), .launch_ready(launch_ready),
    .launch_tag(launch_tag), .launch_mask(launch_mask),
    .launch_collect(launch_collect),
    .rpt_valid(rpt_valid), .rpt_tag(rpt_tag), .rpt_src(rpt_src),
    .rpt_ok(rpt_ok), .rpt_err(rpt_err),
    .res_valid(res_valid), .res_ready(res_ready), .res_tag(res_tag),
    .res_ok(res_ok), .res_err(res_err), .proto_err(proto_err)
  );

  typedef struct packed {
    logic [TW-1:0] tag;
    logic          ok;
    logic [EW-1:0] err;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];
  int    total = 0;
  int    bad = 0;
  bit    finished = 1'b0;

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  exp_t  mon_e;
  string mon_r;
  always @(negedge clk) begin
    if (!rst && res_valid && res_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected result tag", int'(res_tag), -1);
      end else begin
        mon_e = exp_q.pop_front();
        mon_r = req_q.pop_front();
        chk(res_tag == mon_e.tag, mon_r, "result tag", int'(res_tag), int'(mon_e.tag));
        chk(res_ok == mon_e.ok, mon_r, "result ok", int'(res_ok), int'(mon_e.ok));
        chk(res_err == mon_e.err, mon_r, "result code", int'(res_err), int'(mon_e.err));
        chk(res_ok ? (res_err == '0) : (res_err != '0), "R7", "ok/code rule",
            int'(res_err), int'(res_ok));
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; launch_valid = 1'b0; rpt_valid = 1'b0; res_ready = 1'b1;
    exp_q.delete(); req_q.delete();
    cyc(3);
    rst = 1'b0;
    cyc(1);
  endtask

  task automatic launch(input int tag, input int mask, input bit coll);
    while (!launch_ready) cyc(1);
    launch_tag = TW'(tag); launch_mask = N'(mask); launch_collect = coll;
    launch_valid = 1'b1;
    cyc(1);
    launch_valid = 1'b0;
  endtask

  task automatic report(input int tag, input int src, input bit ok, input int err);
    rpt_tag = TW'(tag); rpt_src = SW'(src); rpt_ok = ok; rpt_err = EW'(err);
    rpt_valid = 1'b1;
    cyc(1);
    rpt_valid = 1'b0;
  endtask

  task automatic expect_res(input int tag, input bit ok, input int err, input string req);
    exp_t e;
    e.tag = TW'(tag); e.ok = ok; e.err = EW'(err);
    exp_q.push_back(e);
    req_q.push_back(req);
  endtask

  task automatic drain_wait();
    while (exp_q.size() != 0) cyc(1);
    cyc(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R3 watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(launch_ready == 1'b1, "R1", "launch_ready", int'(launch_ready), 1);
    chk(res_valid == 1'b0, "R1", "res_valid", int'(res_valid), 0);
    chk(proto_err == 1'b0, "R1", "proto_err", int'(proto_err), 0);

    // R3 fail-fast, all ok, latency
    launch(1, 5'b00011, 1'b0);
    chk(launch_ready == 1'b0, "R2", "ready after launch", int'(launch_ready), 0);
    expect_res(1, 1'b1, 0, "R3");
    report(1, 1, 1'b1, 0);
    chk(res_valid == 1'b0, "R3", "early result", int'(res_valid), 0);
    report(1, 0, 1'b1, 0);
    chk(res_valid == 1'b1, "R3", "result one cycle after last report", int'(res_valid), 1);
    drain_wait();

    // R4 fail-fast trip, then R5 absorption
    launch(3, 5'b10111, 1'b0);
    expect_res(3, 1'b0, 5, "R4");
    report(3, 0, 1'b1, 0);
    report(3, 2, 1'b0, 5);
    chk(res_valid == 1'b1, "R4", "fail-fast result", int'(res_valid), 1);
    drain_wait();
    report(3, 1, 1'b1, 0);
    report(3, 4, 1'b0, 2);
    cyc(3);
    chk(proto_err == 1'b0, "R5", "absorbed reports flag", int'(proto_err), 0);
    chk(res_valid == 1'b0, "R5", "absorbed reports output", int'(res_valid), 0);

    // R6 collect-all, lowest failing index wins
    launch(7, 5'b11110, 1'b1);
    expect_res(7, 1'b0, 2, "R6");
    report(7, 4, 1'b0, 6);
    report(7, 1, 1'b1, 0);
    report(7, 3, 1'b0, 2);
    chk(res_valid == 1'b0, "R6", "no result before all", int'(res_valid), 0);
    report(7, 2, 1'b1, 0);
    chk(res_valid == 1'b1, "R6", "result after all", int'(res_valid), 1);
    drain_wait();

    // R6 collect-all, lowest index is the top target, reversed order
    launch(8, 5'b10001, 1'b1);
    expect_res(8, 1'b0, 3, "R6");
    report(8, 4, 1'b0, 3);
    report(8, 0, 1'b1, 0);
    drain_wait();

    // R3 collect-all all ok
    launch(9, 5'b11111, 1'b1);
    expect_res(9, 1'b1, 0, "R3");
    for (int i = 0; i < N; i++) report(9, N - 1 - i, 1'b1, 0);
    drain_wait();

    // R10 empty mask
    launch(4, 0, 1'b0);
    expect_res(4, 1'b1, 0, "R10");
    drain_wait();

    // R2 and R7 backpressure
    res_ready = 1'b0;
    launch(2, 5'b00001, 1'b0);
    expect_res(2, 1'b0, 7, "R7");
    report(2, 0, 1'b0, 7);
    cyc(3);
    chk(res_valid == 1'b1, "R7", "held valid", int'(res_valid), 1);
    chk(res_err == 3'd7, "R7", "held code", int'(res_err), 7);
    chk(launch_ready == 1'b0, "R2", "ready while result held", int'(launch_ready), 0);
    @(posedge clk); #1 res_ready = 1'b1;
    cyc(1);
    cyc(1);
    chk(launch_ready == 1'b1, "R2", "ready after handshake", int'(launch_ready), 1);
    chk(proto_err == 1'b0, "R8", "no flag on legal traffic", int'(proto_err), 0);
    drain_wait();

    // R8 tag mismatch, not counted, sticky
    do_reset();
    launch(5, 5'b00001, 1'b0);
    report(6, 0, 1'b1, 0);
    cyc(1);
    chk(proto_err == 1'b1, "R8", "tag mismatch flag", int'(proto_err), 1);
    chk(res_valid == 1'b0, "R8", "mismatch not counted", int'(res_valid), 0);
    expect_res(5, 1'b1, 0, "R8");
    report(5, 0, 1'b1, 0);
    drain_wait();
    cyc(5);
    chk(proto_err == 1'b1, "R8", "flag sticky", int'(proto_err), 1);

    // R8 target outside mask
    do_reset();
    launch(5, 5'b00010, 1'b0);
    report(5, 0, 1'b1, 0);
    cyc(1);
    chk(proto_err == 1'b1, "R8", "outside mask flag", int'(proto_err), 1);
    chk(res_valid == 1'b0, "R8", "outside mask not counted", int'(res_valid), 0);
    expect_res(5, 1'b1, 0, "R8");
    report(5, 1, 1'b1, 0);
    drain_wait();

    // R8 repeated target
    do_reset();
    launch(6, 5'b00011, 1'b1);
    report(6, 0, 1'b1, 0);
    report(6, 0, 1'b1, 0);
    cyc(1);
    chk(proto_err == 1'b1, "R8", "repeat flag", int'(proto_err), 1);
    chk(res_valid == 1'b0, "R8", "repeat not counted", int'(res_valid), 0);
    expect_res(6, 1'b1, 0, "R8");
    report(6, 1, 1'b1, 0);
    drain_wait();

    // R8 index beyond N_TGT
    do_reset();
    launch(6, 5'b11111, 1'b0);
    report(6, 6, 1'b1, 0);
    cyc(1);
    chk(proto_err == 1'b1, "R8", "index out of range flag", int'(proto_err), 1);

    // R8 report with no open request
    do_reset();
    report(0, 0, 1'b1, 0);
    cyc(1);
    chk(proto_err == 1'b1, "R8", "idle report flag", int'(proto_err), 1);

    // R9 ok with nonzero code
    do_reset();
    launch(10, 5'b00001, 1'b0);
    report(10, 0, 1'b1, 3);
    cyc(1);
    chk(proto_err == 1'b1, "R9", "ok with code flag", int'(proto_err), 1);
    chk(res_valid == 1'b0, "R9", "ok with code not counted", int'(res_valid), 0);
    expect_res(10, 1'b1, 0, "R9");
    report(10, 0, 1'b1, 0);
    drain_wait();

    // R9 fail with null code
    do_reset();
    launch(11, 5'b00001, 1'b0);
    report(11, 0, 1'b0, 0);
    cyc(1);
    chk(proto_err == 1'b1, "R9", "fail with null code flag", int'(proto_err), 1);
    chk(res_valid == 1'b0, "R9", "fail with null code not counted", int'(res_valid), 0);
    expect_res(11, 1'b0, 4, "R9");
    report(11, 0, 1'b0, 4);
    drain_wait();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule